// File: doc/BRIEF.md
# Bridge Request Routing Decoder

This block sits behind the header parser of a two-sided bus bridge. For every incoming request or completion it decides whether the packet goes to the downstream side, is taken by the bridge itself, is dropped, or must be answered as an Unsupported Request. It uses the bridge's programmed bus numbers and address windows. The window registers arrive in their raw, truncated form. The block rebuilds full 64-bit base and limit addresses from them by filling in the implied low bits and, where enabled, the upper-word extension.

Configuration requests are steered by target bus number. When a request is aimed at the bus directly below the bridge, a flag tells the egress logic to rewrite it from Type 1 to Type 0. Memory and I/O requests are steered by address. Completions are steered by the requester's bus number. The decision is registered and appears one clock after the request strobe.

Top module: `bridge_route_decoder`

## Requirements
- R1: A configuration request (kind 0) whose target bus equals the secondary bus gives route 1 (forward) with the Type-0 conversion flag set.
- R2: A configuration request whose target bus is above the secondary bus and at most the subordinate bus gives route 1 with the flag clear. Any other bus number gives route 0 (none).
- R3: The I/O window takes address bits [15:12] from bits [7:4] of the raw base and limit. The low 12 bits are 000h for the base and FFFh for the limit. With base bits [3:0] = 0h the decode is 16-bit only, so any I/O address at or above 10000h misses.
- R4: With I/O base bits [3:0] = 1h, the upper-16 base and limit inputs supply address bits [31:16] of the I/O window.
- R5: The non-prefetchable memory window takes address bits [31:20] from raw bits [15:4]. The low 20 bits are 00000h for the base and FFFFFh for the limit. Bits [63:32] are zero, so any address at or above 2^32 misses it.
- R6: The prefetchable window uses the same encoding as R5. With base bits [3:0] = 1h, its upper-32 inputs supply bits [63:32]. With 0h, those bits are zero and the upper inputs have no effect.
- R7: A window whose rebuilt limit is below its rebuilt base claims no address.
- R8: A memory (kind 1) or I/O (kind 2) request whose address lies in the bridge's own inclusive range gives route 2 (consume). This takes priority over a window hit.
- R9: A memory or I/O request that hits neither the bridge range nor a matching window gives route 3 (Unsupported Request).
- R10: A completion (kind 3) whose requester bus lies in the inclusive range from secondary to subordinate gives route 1. Otherwise it gives route 0.
- R11: When the memory-space enable is low, every memory request gives route 3. When the I/O-space enable is low, every I/O request gives route 3.
- R12: The result valid equals the request valid from the previous clock. When the result valid is low, the route is 0 and the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request fields valid this cycle |
| req_kind | input | 2 | 0 config, 1 memory, 2 I/O, 3 completion |
| req_bus | input | BUS_W | Target bus (config) or requester bus (completion) |
| req_addr | input | 64 | Memory address; I/O uses bits [31:0] |
| sec_bus | input | BUS_W | Secondary bus number |
| sub_bus | input | BUS_W | Subordinate bus number |
| io_base_raw | input | 8 | Raw I/O base register |
| io_limit_raw | input | 8 | Raw I/O limit register |
| io_base_up | input | 16 | I/O base bits [31:16] |
| io_limit_up | input | 16 | I/O limit bits [31:16] |
| mem_base_raw | input | 16 | Raw non-prefetchable base |
| mem_limit_raw | input | 16 | Raw non-prefetchable limit |
| pf_base_raw | input | 16 | Raw prefetchable base |
| pf_limit_raw | input | 16 | Raw prefetchable limit |
| pf_base_up | input | 32 | Prefetchable base bits [63:32] |
| pf_limit_up | input | 32 | Prefetchable limit bits [63:32] |
| own_lo | input | 64 | Lowest address of the bridge's own range |
| own_hi | input | 64 | Highest address of the bridge's own range |
| mem_space_en | input | 1 | Memory space enable |
| io_space_en | input | 1 | I/O space enable |
| rsp_valid | output | 1 | Decision valid |
| rsp_route | output | 2 | 0 none, 1 forward, 2 consume, 3 unsupported |
| rsp_cfg_to_type0 | output | 1 | Rewrite the config request as Type 0 |

## Verification
A fault in window reconstruction shows up as a wrong route exactly at a window edge: at the first or last address, one past the limit, or just above the 16-bit or 32-bit boundary. It appears on the clock after the request. The directed tests therefore probe each window at both ends, on both sides of the width boundary, and with base above limit. Bus-range faults show up at the secondary and subordinate numbers and one step outside them. Since nothing is held between requests, any wrong state is visible on the very next decision.

// File: rtl/rd_pkg.sv
// Package: shared encodings for the bridge routing decoder.
// Assumes a 64-bit address space for all rebuilt windows.
package rd_pkg;
    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {
        KIND_CFG = 2'd0,
        KIND_MEM = 2'd1,
        KIND_IO  = 2'd2,
        KIND_CPL = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        ROUTE_NONE    = 2'd0,
        ROUTE_FWD     = 2'd1,
        ROUTE_CONSUME = 2'd2,
        ROUTE_UR      = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        WIN_IO    = 2'd0,
        WIN_MEM32 = 2'd1,
        WIN_PF64  = 2'd2
    } win_kind_e;
endpackage

// File: rtl/rd_range_cmp.sv
// Module: inclusive range comparator.
// Reports whether the range is open (hi >= lo) and whether val lies in it.
// Assumes unsigned operands of equal width.
module rd_range_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] val,
    output logic         open,
    output logic         hit
);
    // Range is usable only when its top is not below its bottom.
    always_comb begin
        open = (hi >= lo);
        hit  = open && (val >= lo) && (val <= hi);
    end
endmodule

// File: rtl/rd_window_build.sv
// Module: rebuilds a full 64-bit base and limit from raw truncated window
// registers. KIND picks the I/O, 32-bit memory or 64-bit-capable memory
// encoding. Assumes raw registers are presented in their stored form.
module rd_window_build
    import rd_pkg::*;
#(
    parameter win_kind_e KIND = WIN_IO
) (
    input  logic [15:0]       base_raw,
    input  logic [15:0]       limit_raw,
    input  logic [31:0]       base_up,
    input  logic [31:0]       limit_up,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] limit_addr
);
    localparam logic [3:0] WIDE_CODE = 4'h1;

    generate
        if (KIND == WIN_IO) begin : g_io
            logic        wide;
            logic [15:0] b_hi, l_hi;
            logic        unused_io;
            // I/O: 4 KB granules, optional upper 16 bits.
            always_comb begin
                wide       = (base_raw[3:0] == WIDE_CODE);
                b_hi       = wide ? base_up[15:0]  : 16'h0;
                l_hi       = wide ? limit_up[15:0] : 16'h0;
                base_addr  = {32'h0, b_hi, base_raw[7:4],  12'h000};
                limit_addr = {32'h0, l_hi, limit_raw[7:4], 12'hFFF};
            end
            assign unused_io = ^{base_raw[15:8], limit_raw[15:8], limit_raw[3:0],
                                 base_up[31:16], limit_up[31:16]};
        end else if (KIND == WIN_MEM32) begin : g_mem
            logic unused_mem;
            // Non-prefetchable: 1 MB granules, fixed below 4 GB.
            always_comb begin
                base_addr  = {32'h0, base_raw[15:4],  20'h00000};
                limit_addr = {32'h0, limit_raw[15:4], 20'hFFFFF};
            end
            assign unused_mem = ^{base_raw[3:0], limit_raw[3:0], base_up, limit_up};
        end else begin : g_pf
            logic        wide;
            logic [31:0] b_hi, l_hi;
            logic        unused_pf;
            // Prefetchable: 1 MB granules, optional upper 32 bits.
            always_comb begin
                wide       = (base_raw[3:0] == WIDE_CODE);
                b_hi       = wide ? base_up  : 32'h0;
                l_hi       = wide ? limit_up : 32'h0;
                base_addr  = {b_hi, base_raw[15:4],  20'h00000};
                limit_addr = {l_hi, limit_raw[15:4], 20'hFFFFF};
            end
            assign unused_pf = ^limit_raw[3:0];
        end
    endgenerate
endmodule

// File: rtl/bridge_route_decoder.sv
// Module: routing decision for one request or completion at a bridge.
// Config requests are steered by bus number, memory and I/O requests by address
// windows plus the bridge's own range, completions by requester bus.
// The result is registered: valid one clock after req_valid.
// Assumes the request fields are stable while req_valid is high.
module bridge_route_decoder
    import rd_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [63:0]       req_addr,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic [7:0]        io_base_raw,
    input  logic [7:0]        io_limit_raw,
    input  logic [15:0]       io_base_up,
    input  logic [15:0]       io_limit_up,
    input  logic [15:0]       mem_base_raw,
    input  logic [15:0]       mem_limit_raw,
    input  logic [15:0]       pf_base_raw,
    input  logic [15:0]       pf_limit_raw,
    input  logic [31:0]       pf_base_up,
    input  logic [31:0]       pf_limit_up,
    input  logic [63:0]       own_lo,
    input  logic [63:0]       own_hi,
    input  logic              mem_space_en,
    input  logic              io_space_en,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic              rsp_cfg_to_type0
);
    localparam int IO_AW = 32;

    logic [ADDR_W-1:0] io_b, io_l, np_b, np_l, pf_b, pf_l;
    logic [ADDR_W-1:0] io_addr;
    logic io_open, np_open, pf_open, own_open;
    logic io_hit, np_hit, pf_hit, own_mem_hit, own_io_hit, own_io_open;
    logic cpl_open, cpl_hit;
    logic cfg_t0, cfg_t1;
    route_e route_d;
    logic   t0_d;

    // I/O requests only carry 32 address bits.
    assign io_addr = {{(ADDR_W-IO_AW){1'b0}}, req_addr[IO_AW-1:0]};

    rd_window_build #(.KIND(WIN_IO)) u_io_win (
        .base_raw ({8'h0, io_base_raw}), .limit_raw({8'h0, io_limit_raw}),
        .base_up  ({16'h0, io_base_up}), .limit_up ({16'h0, io_limit_up}),
        .base_addr(io_b), .limit_addr(io_l));

    rd_window_build #(.KIND(WIN_MEM32)) u_np_win (
        .base_raw (mem_base_raw), .limit_raw(mem_limit_raw),
        .base_up  (32'h0), .limit_up (32'h0),
        .base_addr(np_b), .limit_addr(np_l));

    rd_window_build #(.KIND(WIN_PF64)) u_pf_win (
        .base_raw (pf_base_raw), .limit_raw(pf_limit_raw),
        .base_up  (pf_base_up), .limit_up (pf_limit_up),
        .base_addr(pf_b), .limit_addr(pf_l));

    rd_range_cmp #(.W(ADDR_W)) u_io_cmp  (.lo(io_b), .hi(io_l), .val(io_addr),
                                          .open(io_open), .hit(io_hit));
    rd_range_cmp #(.W(ADDR_W)) u_np_cmp  (.lo(np_b), .hi(np_l), .val(req_addr),
                                          .open(np_open), .hit(np_hit));
    rd_range_cmp #(.W(ADDR_W)) u_pf_cmp  (.lo(pf_b), .hi(pf_l), .val(req_addr),
                                          .open(pf_open), .hit(pf_hit));
    rd_range_cmp #(.W(ADDR_W)) u_own_mem (.lo(own_lo), .hi(own_hi), .val(req_addr),
                                          .open(own_open), .hit(own_mem_hit));
    rd_range_cmp #(.W(ADDR_W)) u_own_io  (.lo(own_lo), .hi(own_hi), .val(io_addr),
                                          .open(own_io_open), .hit(own_io_hit));
    rd_range_cmp #(.W(BUS_W))  u_cpl_cmp (.lo(sec_bus), .hi(sub_bus), .val(req_bus),
                                          .open(cpl_open), .hit(cpl_hit));

    logic unused_open;
    assign unused_open = ^{io_open, np_open, pf_open, own_open, own_io_open, cpl_open};

    // Bus-number classification for configuration requests.
    always_comb begin
        cfg_t0 = (req_bus == sec_bus);
        cfg_t1 = (req_bus > sec_bus) && (req_bus <= sub_bus);
    end

    // Next routing decision by request kind.
    always_comb begin
        route_d = ROUTE_NONE;
        t0_d    = 1'b0;
        if (req_valid) begin
            unique case (req_kind_e'(req_kind))
                KIND_CFG: begin
                    if (cfg_t0) begin
                        route_d = ROUTE_FWD;
                        t0_d    = 1'b1;
                    end else if (cfg_t1) begin
                        route_d = ROUTE_FWD;
                    end
                end
                KIND_MEM: begin
                    if (!mem_space_en)            route_d = ROUTE_UR;
                    else if (own_mem_hit)         route_d = ROUTE_CONSUME;
                    else if (np_hit || pf_hit)    route_d = ROUTE_FWD;
                    else                          route_d = ROUTE_UR;
                end
                KIND_IO: begin
                    if (!io_space_en)             route_d = ROUTE_UR;
                    else if (own_io_hit)          route_d = ROUTE_CONSUME;
                    else if (io_hit)              route_d = ROUTE_FWD;
                    else                          route_d = ROUTE_UR;
                end
                KIND_CPL: begin
                    if (cpl_hit)                  route_d = ROUTE_FWD;
                end
                default: route_d = ROUTE_NONE;
            endcase
        end
    end

    // Result register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_route        <= ROUTE_NONE;
            rsp_cfg_to_type0 <= 1'b0;
        end else begin
            rsp_valid        <= req_valid;
            rsp_route        <= route_d;
            rsp_cfg_to_type0 <= t0_d;
        end
    end

    // R12: result valid tracks the request strobe one clock later.
    assert_valid_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R12: an idle result carries no route and no conversion.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_route == ROUTE_NONE && !rsp_cfg_to_type0));

    // R1: the conversion flag only accompanies a forward.
    assert_t0_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cfg_to_type0 |-> (rsp_route == ROUTE_FWD));

    // R1: a config request aimed at the secondary bus is converted.
    assert_sec_convert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_kind) == KIND_CFG
         && $past(req_bus) == $past(sec_bus)) |-> rsp_cfg_to_type0);

    // R10: completions are never consumed or rejected.
    assert_cpl_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_kind) == KIND_CPL)
        |-> (rsp_route == ROUTE_NONE || rsp_route == ROUTE_FWD));

    // R11: memory with space disabled is always rejected.
    assert_mem_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_kind) == KIND_MEM
         && !$past(mem_space_en)) |-> (rsp_route == ROUTE_UR));
endmodule

// File: tb/bridge_route_decoder_test.sv
// Directed bench for the bridge routing decoder.
module bridge_route_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_bus = 8'd0;
    logic [63:0] req_addr = 64'd0;
    logic [7:0]  sec_bus = 8'd2, sub_bus = 8'd5;
    logic [7:0]  io_base_raw = 8'hF0, io_limit_raw = 8'h00;
    logic [15:0] io_base_up = 16'h0, io_limit_up = 16'h0;
    logic [15:0] mem_base_raw = 16'hFFF0, mem_limit_raw = 16'h0000;
    logic [15:0] pf_base_raw = 16'hFFF0, pf_limit_raw = 16'h0000;
    logic [31:0] pf_base_up = 32'h0, pf_limit_up = 32'h0;
    logic [63:0] own_lo = 64'd1, own_hi = 64'd0;
    logic        mem_space_en = 1'b1, io_space_en = 1'b1;
    logic        rsp_valid, rsp_cfg_to_type0;
    logic [1:0]  rsp_route;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] NONE = 2'd0, FWD = 2'd1, CONS = 2'd2, UR = 2'd3;
    localparam logic [1:0] CFG = 2'd0, MEM = 2'd1, IO = 2'd2, CPL = 2'd3;

    always #2.5 clk = ~clk;

    bridge_route_decoder uut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic expect_out(input string tag, input logic v,
                              input logic [1:0] r, input logic t0);
        checks++;
        if (rsp_valid !== v || rsp_route !== r || rsp_cfg_to_type0 !== t0) begin
            errors++;
            $display("FAIL %s: actual v=%0b route=%0d t0=%0b expected v=%0b route=%0d t0=%0b",
                     tag, rsp_valid, rsp_route, rsp_cfg_to_type0, v, r, t0);
        end
    endtask

    // Present one request, check the registered result, then go idle.
    task automatic send(input string tag, input logic [1:0] k, input logic [7:0] b,
                        input logic [63:0] a, input logic [1:0] r, input logic t0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_bus = b; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        expect_out(tag, 1'b1, r, t0);
    endtask

    task automatic t_reset;
        expect_out("R12 reset", 1'b0, NONE, 1'b0);
    endtask

    task automatic t_cfg;
        send("R1 sec bus", CFG, 8'd2, 64'd0, FWD, 1'b1);
        send("R2 sec+1", CFG, 8'd3, 64'd0, FWD, 1'b0);
        send("R2 sub", CFG, 8'd5, 64'd0, FWD, 1'b0);
        send("R2 above sub", CFG, 8'd6, 64'd0, NONE, 1'b0);
        send("R2 below sec", CFG, 8'd1, 64'd0, NONE, 1'b0);
    endtask

    task automatic t_io16;
        io_base_raw = 8'h40; io_limit_raw = 8'h4F;
        io_base_up = 16'h0001; io_limit_up = 16'h0001;
        send("R3 io first", IO, 0, 64'h4000, FWD, 1'b0);
        send("R3 io last", IO, 0, 64'h4FFF, FWD, 1'b0);
        send("R3 io past", IO, 0, 64'h5000, UR, 1'b0);
        send("R3 io 16bit", IO, 0, 64'h1_4000, UR, 1'b0);
    endtask

    task automatic t_io32;
        io_base_raw = 8'h41; io_limit_raw = 8'h41;
        send("R4 io wide", IO, 0, 64'h1_4000, FWD, 1'b0);
        send("R4 io low", IO, 0, 64'h4000, UR, 1'b0);
        io_space_en = 1'b0;
        send("R11 io off", IO, 0, 64'h1_4000, UR, 1'b0);
        io_space_en = 1'b1;
        io_base_raw = 8'hF0; io_limit_raw = 8'h00;
        send("R7 io closed", IO, 0, 64'hF000, UR, 1'b0);
    endtask

    task automatic t_np;
        mem_base_raw = 16'hF900; mem_limit_raw = 16'hF900;
        send("R5 np first", MEM, 0, 64'hF900_0000, FWD, 1'b0);
        send("R5 np last", MEM, 0, 64'hF90F_FFFF, FWD, 1'b0);
        send("R5 np past", MEM, 0, 64'hF910_0000, UR, 1'b0);
        send("R5 np above4G", MEM, 0, 64'h1_F900_0000, UR, 1'b0);
    endtask

    task automatic t_own;
        own_lo = 64'hF900_0000; own_hi = 64'hF900_0FFF;
        send("R8 own in win", MEM, 0, 64'hF900_0800, CONS, 1'b0);
        send("R8 own past", MEM, 0, 64'hF900_1000, FWD, 1'b0);
        mem_space_en = 1'b0;
        send("R11 mem off", MEM, 0, 64'hF900_0800, UR, 1'b0);
        mem_space_en = 1'b1;
        own_lo = 64'd1; own_hi = 64'd0;
        mem_base_raw = 16'hFFF0; mem_limit_raw = 16'h0000;
        send("R7 np closed", MEM, 0, 64'h0, UR, 1'b0);
        send("R9 mem miss", MEM, 0, 64'h8000_0000, UR, 1'b0);
    endtask

    task automatic t_pf;
        pf_base_raw = 16'h1001; pf_limit_raw = 16'h1FF1;
        pf_base_up = 32'h2; pf_limit_up = 32'h2;
        send("R6 pf wide", MEM, 0, 64'h2_1000_0000, FWD, 1'b0);
        send("R6 pf wide top", MEM, 0, 64'h2_1FFF_FFFF, FWD, 1'b0);
        send("R6 pf low", MEM, 0, 64'h1000_0000, UR, 1'b0);
        pf_base_raw = 16'h1000; pf_limit_raw = 16'h1FF0;
        send("R6 pf narrow", MEM, 0, 64'h1000_0000, FWD, 1'b0);
        send("R6 pf narrow hi", MEM, 0, 64'h2_1000_0000, UR, 1'b0);
        pf_base_raw = 16'hFFF1; pf_limit_raw = 16'h0001;
        send("R7 pf closed", MEM, 0, 64'h2_1000_0000, UR, 1'b0);
    endtask

    task automatic t_cpl;
        send("R10 cpl sec", CPL, 8'd2, 64'd0, FWD, 1'b0);
        send("R10 cpl sub", CPL, 8'd5, 64'd0, FWD, 1'b0);
        send("R10 cpl low", CPL, 8'd1, 64'd0, NONE, 1'b0);
        send("R10 cpl high", CPL, 8'd6, 64'd0, NONE, 1'b0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        expect_out("R12 idle", 1'b0, NONE, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cfg();
        t_io16();
        t_io32();
        t_np();
        t_own();
        t_pf();
        t_cpl();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule